// File: doc/BRIEF.md
# Per-Channel Fault Diagnostic Capture

This block gathers fault reports from a bank of power-stage channels and keeps them as compact diagnostic registers that a serial upstream link can read. Every channel supplies four raw fault indications: open load, short to ground, short to battery and over-temperature. A raw fault must hold steady for a programmable number of clock cycles before it is stored. This filtering rejects glitches from the analog detectors.

Each channel keeps a 2-bit fault code, and a more recent qualified fault replaces an older one. Over-temperature is filtered separately on each channel. It is reported through a shared warning bit, next to a shared failure flag. A read request returns the selected register as it stood just before the read and clears that register in the same clock edge. A fault that qualifies in that same edge survives the clear.

The serial framing and the analog detectors sit outside this block. The framing logic drives the read request and register select, and it shifts out the returned byte.

Top module: `fault_diag_capture`

## Requirements
- R1: While `rst_n` is low and after its release, every stored code and over-temperature bit is zero, `rd_valid` is 0 and `rd_data` is 0.
- R2: A raw fault is stored only after it has been present with the same type for FILT_LEN consecutive clock cycles. A fault that lasts fewer cycles leaves no trace.
- R3: The filter count of a channel restarts when the raw fault type changes or disappears. Two different types that each last fewer than FILT_LEN cycles store nothing.
- R4: When several raw faults are present together, the code stored is short to battery over short to ground over open load. The codes are 00 none, 01 open load, 10 short to ground and 11 short to battery.
- R5: A later qualified fault of another type overwrites the stored code. The code stays stored after the raw fault goes away, until it is read.
- R6: Registers 0 to 4 hold the channel codes, four channels per byte. Channel 4r+i sits in bits [2i+1:2i] of register r, and unused bits are 0. A read request on `rd_sel` gives `rd_valid`=1 with the pre-clear register contents on `rd_data` one cycle later, and clears the codes held in that register. With no read, `rd_valid` and `rd_data` are 0.
- R7: If a fault qualifies in the same cycle that its register is cleared by a read, the fault is kept.
- R8: Register 5 is the flag register. Bit 0 is the failure flag: any stored code nonzero, or any over-temperature bit set. Bit 1 is the over-temperature warning. All other bits are 0. Reading it clears every over-temperature bit and no channel code.
- R9: Over-temperature passes through its own FILT_LEN filter per channel, independent of the code filter. A shorter over-temperature pulse sets nothing.
- R10: A read of select values 6 or 7 returns 0 and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_open | input | NUM_CH | Raw open-load indication per channel |
| flt_gnd | input | NUM_CH | Raw short-to-ground indication per channel |
| flt_bat | input | NUM_CH | Raw short-to-battery indication per channel |
| flt_hot | input | NUM_CH | Raw over-temperature indication per channel |
| rd_req | input | 1 | One-cycle read strobe |
| rd_sel | input | SEL_W | Register select, 0 to 5 valid |
| rd_data | output | 2*CH_PER_REG | Snapshot of the selected register |
| rd_valid | output | 1 | Marks `rd_data` as a read result |

## Verification
The assertions check the following on every cycle:
- a filter restarts at count one on a type change;
- a filter drops qualification when the raw input vanishes;
- a code becomes nonzero only after a qualification;
- the set-over-clear priority holds in the storage cell;
- the read strobe timing is kept, and `rd_data` is zero outside a read.

Only the bench scenarios can show the following:
- the full filter length and the rejection of short pulses;
- the encoding priority between simultaneous faults;
- the register packing;
- the pre-clear snapshot, the flag register and the effect of invalid selects.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

  typedef enum logic [1:0] {
    FC_NONE = 2'b00,
    FC_OPEN = 2'b01,
    FC_GND  = 2'b10,
    FC_BAT  = 2'b11
  } fault_code_e;

  // Battery short dominates ground short, which dominates open load.
  function automatic logic [1:0] fc_pick(input logic op, input logic gnd, input logic bat);
    logic [1:0] res;
    if (bat)      res = FC_BAT;
    else if (gnd) res = FC_GND;
    else if (op)  res = FC_OPEN;
    else          res = FC_NONE;
    return res;
  endfunction

endpackage

// File: rtl/fdc_filter.sv
module fdc_filter #(
  parameter int FILT_LEN = 16,
  localparam int CW = $clog2(FILT_LEN + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] raw_code,
  output logic       qual,
  output logic [1:0] qual_code
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    typ_q, typ_d;
  logic          upd_en;

  always_comb begin
    cnt_d = cnt_q;
    typ_d = typ_q;
    if (raw_code == 2'b00) begin
      cnt_d = '0;
      typ_d = 2'b00;
    end else if (raw_code != typ_q) begin
      cnt_d = CW'(1);
      typ_d = raw_code;
    end else if (cnt_q != CW'(FILT_LEN)) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  assign upd_en = (cnt_d != cnt_q) || (typ_d != typ_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      typ_q <= 2'b00;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      typ_q <= typ_d;
    end
  end

  assign qual      = (typ_q != 2'b00) && (cnt_q == CW'(FILT_LEN));
  assign qual_code = typ_q;

  // R3: a new type restarts the count at one
  a_r3_restart_count: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_code != 2'b00 && raw_code != typ_q) |=> (cnt_q == CW'(1) && typ_q == $past(raw_code)));

  // R2: a vanished raw fault is never qualified in the next cycle
  a_r2_drop_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_code == 2'b00) |=> !qual);

endmodule

// File: rtl/fdc_store.sv
module fdc_store (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       code_qual,
  input  logic [1:0] code_new,
  input  logic       code_clr,
  input  logic       hot_qual,
  input  logic       hot_clr,
  output logic [1:0] code_q,
  output logic       hot_q
);

  logic [1:0] code_d;
  logic       code_en;
  logic       hot_d;
  logic       hot_en;

  // A qualifying fault wins over a clear in the same cycle.
  always_comb begin
    code_en = code_qual || code_clr;
    code_d  = code_qual ? code_new : 2'b00;
    hot_en  = hot_qual || hot_clr;
    hot_d   = hot_qual;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= 2'b00;
    end else if (code_en) begin
      code_q <= code_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_q <= 1'b0;
    end else if (hot_en) begin
      hot_q <= hot_d;
    end
  end

  // R2: a nonzero code appears only after a qualification
  a_r2_code_needs_qual: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != 2'b00 && code_q != $past(code_q)) |-> $past(code_qual));

  // R7: a qualification coinciding with a clear is kept
  a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (code_qual && code_clr) |=> (code_q == $past(code_new)));

  // R6: a clear without a qualification empties the code
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (code_clr && !code_qual) |=> (code_q == 2'b00));

  // R9: over-temperature bit rises only after its own qualification
  a_r9_hot_needs_qual: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hot_q) |-> $past(hot_qual));

endmodule

// File: rtl/fdc_readout.sv
module fdc_readout #(
  parameter int NUM_CH     = 18,
  parameter int CH_PER_REG = 4,
  localparam int NREG_CODE = (NUM_CH + CH_PER_REG - 1) / CH_PER_REG,
  localparam int FLAG_IDX  = NREG_CODE,
  localparam int SEL_W     = $clog2(FLAG_IDX + 1),
  localparam int DATA_W    = 2 * CH_PER_REG
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*NUM_CH-1:0] codes,
  input  logic [NUM_CH-1:0]   hots,
  input  logic                rd_req,
  input  logic [SEL_W-1:0]    rd_sel,
  output logic [NUM_CH-1:0]   clr_code,
  output logic                clr_hot,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_valid
);

  logic [DATA_W-1:0] img [0:FLAG_IDX];
  logic [DATA_W-1:0] sel_data;
  logic [DATA_W-1:0] data_d;
  logic              any_code;
  logic              any_hot;

  // Code registers: channel r*CH_PER_REG+i in bit pair i of register r.
  for (genvar r = 0; r < NREG_CODE; r++) begin : g_reg
    for (genvar i = 0; i < CH_PER_REG; i++) begin : g_slot
      localparam int CH = r * CH_PER_REG + i;
      if (CH < NUM_CH) begin : g_used
        assign img[r][2*i +: 2] = codes[2*CH +: 2];
      end else begin : g_pad
        assign img[r][2*i +: 2] = 2'b00;
      end
    end
  end

  assign any_code = |codes;
  assign any_hot  = |hots;
  assign img[FLAG_IDX] = {{(DATA_W-2){1'b0}}, any_hot, any_code | any_hot};

  // Clear strobes for the channels of the addressed register.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_clr
    assign clr_code[c] = rd_req && (rd_sel == SEL_W'(c / CH_PER_REG));
  end
  assign clr_hot = rd_req && (rd_sel == SEL_W'(FLAG_IDX));

  always_comb begin
    sel_data = '0;
    for (int k = 0; k <= FLAG_IDX; k++) begin
      if (rd_sel == SEL_W'(k)) sel_data = img[k];
    end
    data_d = rd_req ? sel_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_data  <= data_d;
      rd_valid <= rd_req;
    end
  end

  // R6: result strobe follows the request by one cycle
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  a_r6_valid_only_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  // R6: data bus is quiet outside a read result
  a_r6_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));

  // R10: out-of-range selects clear nothing
  a_r10_no_stray_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel > SEL_W'(FLAG_IDX)) |-> (clr_code == '0 && !clr_hot));

  // R6: at most one register is addressed, so clears hit one group
  a_r6_single_group: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(clr_code) <= CH_PER_REG));

endmodule

// File: rtl/fault_diag_capture.sv
module fault_diag_capture #(
  parameter int NUM_CH     = 18,
  parameter int CH_PER_REG = 4,
  parameter int FILT_LEN   = 16,
  localparam int NREG_CODE = (NUM_CH + CH_PER_REG - 1) / CH_PER_REG,
  localparam int SEL_W     = $clog2(NREG_CODE + 2),
  localparam int DATA_W    = 2 * CH_PER_REG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] flt_open,
  input  logic [NUM_CH-1:0] flt_gnd,
  input  logic [NUM_CH-1:0] flt_bat,
  input  logic [NUM_CH-1:0] flt_hot,
  input  logic              rd_req,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  import fdc_pkg::*;

  logic [2*NUM_CH-1:0] codes;
  logic [NUM_CH-1:0]   hots;
  logic [NUM_CH-1:0]   clr_code;
  logic                clr_hot;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [1:0] raw_c;
    logic       q_c;
    logic [1:0] qc_c;
    logic       q_h;
    logic [1:0] qh_code;

    assign raw_c = fc_pick(flt_open[c], flt_gnd[c], flt_bat[c]);

    fdc_filter #(.FILT_LEN(FILT_LEN)) u_fcode (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_code  (raw_c),
      .qual      (q_c),
      .qual_code (qc_c)
    );

    fdc_filter #(.FILT_LEN(FILT_LEN)) u_fhot (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_code  ({1'b0, flt_hot[c]}),
      .qual      (q_h),
      .qual_code (qh_code)
    );

    fdc_store u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .code_qual (q_c),
      .code_new  (qc_c),
      .code_clr  (clr_code[c]),
      .hot_qual  (q_h && qh_code[0]),
      .hot_clr   (clr_hot),
      .code_q    (codes[2*c +: 2]),
      .hot_q     (hots[c])
    );
  end

  fdc_readout #(
    .NUM_CH     (NUM_CH),
    .CH_PER_REG (CH_PER_REG)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .codes    (codes),
    .hots     (hots),
    .rd_req   (rd_req),
    .rd_sel   (rd_sel),
    .clr_code (clr_code),
    .clr_hot  (clr_hot),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  // R8: reading the flag register never touches the channel codes
  a_r8_flag_read_keeps_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hot && clr_code == '0) |=> (codes == $past(codes) || $past(codes) == '0 || codes != '0));

endmodule

// File: tb/fault_diag_capture_test.sv
module fault_diag_capture_test;

  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 18;
  localparam int FILT = 5;

  logic           clk;
  logic           rst_n;
  logic [NCH-1:0] flt_open, flt_gnd, flt_bat, flt_hot;
  logic           rd_req;
  logic [2:0]     rd_sel;
  logic [7:0]     rd_data;
  logic           rd_valid;

  int n_chk  = 0;
  int n_fail = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  fault_diag_capture #(.NUM_CH(NCH), .CH_PER_REG(4), .FILT_LEN(FILT)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .flt_open (flt_open),
    .flt_gnd  (flt_gnd),
    .flt_bat  (flt_bat),
    .flt_hot  (flt_hot),
    .rd_req   (rd_req),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: push the expected byte, then pulse a read.
  task automatic read_reg(input logic [2:0] sel, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_sel = sel;
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: pop and compare each read result.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk("R6 unexpected result", rd_data, 8'hxx);
      end else begin
        chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rd_req = 1'b0; rd_sel = 3'd0;
    flt_open = '0; flt_gnd = '0; flt_bat = '0; flt_hot = '0;
    wait_n(3);
    chk("R1 valid in reset", {7'd0, rd_valid}, 8'h00);
    chk("R1 data in reset", rd_data, 8'h00);
    rst_n = 1'b1;
    wait_n(2);
    chk("R1 valid after reset", {7'd0, rd_valid}, 8'h00);
    for (int s = 0; s < 6; s++) read_reg(3'(s), 8'h00, "R1 empty register");

    // R2 + R6: open load on ch0 qualifies, read returns then clears
    flt_open[0] = 1'b1; wait_n(FILT + 2); flt_open[0] = 1'b0; wait_n(2);
    read_reg(3'd0, 8'h01, "R2/R6 ch0 open stored");
    read_reg(3'd0, 8'h00, "R6 cleared after read");
    chk("R6 idle bus", rd_data, 8'h00);

    // R2: short pulse is rejected
    flt_gnd[1] = 1'b1; wait_n(FILT - 1); flt_gnd[1] = 1'b0; wait_n(3);
    read_reg(3'd0, 8'h00, "R2 short pulse ignored");

    // R3: type change restarts the filter
    flt_open[2] = 1'b1; wait_n(FILT - 1);
    flt_open[2] = 1'b0; flt_gnd[2] = 1'b1; wait_n(FILT - 1);
    flt_gnd[2] = 1'b0; wait_n(3);
    read_reg(3'd0, 8'h00, "R3 restart on type change");

    // R4: priority among simultaneous faults, register 1 packing
    flt_open[5] = 1'b1; flt_gnd[5] = 1'b1; flt_bat[5] = 1'b1;
    flt_open[6] = 1'b1; flt_gnd[6] = 1'b1;
    wait_n(FILT + 2);
    flt_open = '0; flt_gnd = '0; flt_bat = '0; wait_n(2);
    read_reg(3'd1, 8'h2C, "R4 priority bat>gnd>open");

    // R5: later fault overwrites, code retained after release
    flt_open[17] = 1'b1; wait_n(FILT + 2);
    flt_open[17] = 1'b0; flt_bat[17] = 1'b1; wait_n(FILT + 2);
    flt_bat[17] = 1'b0;
    flt_gnd[16] = 1'b1; wait_n(FILT + 2); flt_gnd[16] = 1'b0; wait_n(3);
    read_reg(3'd4, 8'h0E, "R5 overwrite ch17 and ch16");

    // R9: short over-temperature pulse sets nothing
    flt_hot[3] = 1'b1; wait_n(FILT - 1); flt_hot[3] = 1'b0; wait_n(3);
    read_reg(3'd5, 8'h00, "R9 short hot pulse ignored");

    // R8/R9: qualified over-temperature reported and cleared by flag read
    flt_hot[9] = 1'b1; wait_n(FILT + 2); flt_hot[9] = 1'b0; wait_n(2);
    read_reg(3'd2, 8'h00, "R9 hot does not enter code");
    read_reg(3'd5, 8'h03, "R8 flag with warning");
    read_reg(3'd5, 8'h00, "R8 warning cleared");

    // R8: flag read keeps codes
    flt_gnd[10] = 1'b1; wait_n(FILT + 2); flt_gnd[10] = 1'b0; wait_n(2);
    read_reg(3'd5, 8'h01, "R8 failure flag from code");
    read_reg(3'd5, 8'h01, "R8 flag read left code");
    read_reg(3'd2, 8'h20, "R8 ch10 code intact");
    read_reg(3'd5, 8'h00, "R8 flag clear after code read");

    // R10: invalid selects return zero and clear nothing
    flt_open[12] = 1'b1; wait_n(FILT + 2); flt_open[12] = 1'b0; wait_n(2);
    read_reg(3'd6, 8'h00, "R10 select 6");
    read_reg(3'd7, 8'h00, "R10 select 7");
    read_reg(3'd3, 8'h01, "R10 ch12 survived");

    // R7: qualification during the clearing read is kept
    flt_gnd[13] = 1'b1; wait_n(FILT + 3);
    read_reg(3'd3, 8'h08, "R7 read while fault held");
    flt_gnd[13] = 1'b0; wait_n(2);
    read_reg(3'd3, 8'h08, "R7 code kept through clear");
    read_reg(3'd3, 8'h00, "R7 cleared afterwards");

    wait_n(3);
    chk("R6 queue drained", 8'(exp_q.size()), 8'h00);
    chk("R6 valid idle", {7'd0, rd_valid}, 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule